// File: doc/BRIEF.md
# Bidirectional PWM Motor Drive Generator

This block turns an 8-bit speed command into a single pulse-width-modulated drive signal for an H-bridge. The signal also encodes direction. A high level drives the motor forward and a low level drives it in reverse. At a 50% duty the two directions cancel, so the motor holds still with holding torque. Commands toward 8'hFF raise the forward speed, and commands toward 8'h00 raise the reverse speed.

The duty comes from two down-counters that share one period of `2**SPEED_W * STEP_CLKS` clocks. With the default 256 steps of 120 clocks this is 30,720 clocks, about 260 Hz from an 8 MHz clock. The integrator sets the clock and `STEP_CLKS` so that the drive frequency stays between 60 Hz and 1000 Hz.

- The period counter wraps once per period and emits the clear pulse.
- At each wrap the phase counter is reloaded with `PERIOD-1 - speed*STEP_CLKS`. It emits the set pulse when it reaches zero.
- A set/reset flip-flop, with clear taking priority, forms the drive output.

A speed command is captured on an update strobe. It is applied only when the period counter wraps, so no period is ever cut short.

Top module: `motor_pwm_gen`

## Requirements
- R1: The clear pulse is one clock wide and repeats every PERIOD = 2**SPEED_W * STEP_CLKS clocks. Counting the first clock after reset release as clock 0, it first appears in clock PERIOD-1.
- R2: `pwm_o` rises in the clock after a set pulse and falls in the clock after a clear pulse. Otherwise it holds its value.
- R3: In steady state with active speed S, exactly one set pulse occurs per period, S*STEP_CLKS clocks before the clear pulse. `pwm_o` is high for exactly S*STEP_CLKS clocks of each period.
- R4: During reset, `pwm_o`, `set_pulse_o` and `clr_pulse_o` are 0. After reset the active speed is midscale (2**(SPEED_W-1)), which gives 50% duty from the first period.
- R5: The set and clear pulses never occur in the same clock; clear wins. With speed 0 no set pulse appears and `pwm_o` stays 0 (full reverse).
- R6: With speed 2**SPEED_W-1, `pwm_o` is low for exactly STEP_CLKS clocks per period (full forward).
- R7: A value strobed in mid-period leaves the current period unchanged. It applies from the period that starts after the next clear pulse.
- R8: A value strobed in the same clock as a clear pulse applies one full period later, after the following clear pulse.
- R9: If several strobes fall within one period, the last one before the clear pulse is the one applied.
- R10: A change of `speed_i` without `speed_upd_i` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | SPEED_W | Speed and direction command; midscale means stopped |
| speed_upd_i | input | 1 | Strobe that captures `speed_i` |
| pwm_o | output | 1 | Drive level: 1 forward, 0 reverse |
| set_pulse_o | output | 1 | One-clock pulse that sets the drive flip-flop |
| clr_pulse_o | output | 1 | One-clock pulse that clears the drive flip-flop; marks the period boundary |

## Verification
The hardest case to reach from the ports is a strobe that lands in the very clock in which the clear pulse is visible. In that clock the capture and the boundary reload happen on the same edge, and the old value must win. The bench first synchronises to a clear pulse. It then drives the strobe at once in that clock, before any edge passes, and checks that the next period keeps the old duty and the one after it takes the new duty. Mid-period strobes, double strobes and unstrobed changes of `speed_i` are placed at fixed offsets within a measured period.

// File: rtl/motor_pwm_pkg.sv
package motor_pwm_pkg;
  typedef struct packed {
    logic set;
    logic clr;
  } pulse_pair_t;
endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int PERIOD = 30720,
  parameter int CNT_W  = $clog2(PERIOD)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic wrap_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= LAST;
    else if (cnt_q == '0) cnt_q <= LAST;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  assign wrap_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
  parameter int          PERIOD  = 30720,
  parameter int          CNT_W   = $clog2(PERIOD),
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  // reload at the period boundary dominates the natural wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= RST_VAL;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q == '0) cnt_q <= LAST;
    else                  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pwm_srff.sv
module pwm_srff
  import motor_pwm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  pulse_pair_t req_i,
  output logic        q_o,
  output logic        set_o,
  output logic        clr_o
);
  logic q_q;

  assign clr_o = req_i.clr;
  assign set_o = req_i.set & ~req_i.clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= 1'b0;
    else if (clr_o) q_q <= 1'b0;
    else if (set_o) q_q <= 1'b1;
  end

  assign q_o = q_q;
endmodule

// File: rtl/motor_pwm_gen.sv
module motor_pwm_gen
  import motor_pwm_pkg::*;
#(
  parameter int SPEED_W   = 8,
  parameter int STEP_CLKS = 120
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SPEED_W-1:0] speed_i,
  input  logic               speed_upd_i,
  output logic               pwm_o,
  output logic               set_pulse_o,
  output logic               clr_pulse_o
);
  localparam int STEPS  = 1 << SPEED_W;
  localparam int PERIOD = STEPS * STEP_CLKS;
  localparam int CNT_W  = $clog2(PERIOD);
  localparam logic [SPEED_W-1:0] MID  = SPEED_W'(STEPS / 2);
  localparam logic [CNT_W-1:0]   LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0]   STEP = CNT_W'(STEP_CLKS);
  localparam logic [CNT_W-1:0]   RST_PHASE = CNT_W'(PERIOD - 1 - (STEPS / 2) * STEP_CLKS);

  logic [SPEED_W-1:0] pend_q;
  logic [CNT_W-1:0]   phase_val;
  logic               wrap;
  logic               phase_zero;
  pulse_pair_t        req;

  // command is held until the period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= MID;
    else if (speed_upd_i) pend_q <= speed_i;
  end

  // set pulse lands speed*STEP clocks before the next clear pulse
  assign phase_val = LAST - CNT_W'(pend_q) * STEP;

  pwm_period_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_period (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_o (wrap)
  );

  pwm_phase_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W), .RST_VAL(RST_PHASE)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wrap),
    .load_val_i (phase_val),
    .zero_o     (phase_zero)
  );

  assign req.set = phase_zero;
  assign req.clr = wrap;

  pwm_srff u_ff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .q_o    (pwm_o),
    .set_o  (set_pulse_o),
    .clr_o  (clr_pulse_o)
  );
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int PERIOD = 30720
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwm_i,
  input logic set_i,
  input logic clr_i
);
  localparam int CNT_W = $clog2(PERIOD);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] gap_q;
  logic             set_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gap_q <= '0;
    else if (clr_i) gap_q <= '0;
    else            gap_q <= gap_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    set_seen_q <= 1'b0;
    else if (clr_i) set_seen_q <= 1'b0;
    else if (set_i) set_seen_q <= 1'b1;
  end

  assert_clr_on_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> (gap_q == LAST));
  assert_period_has_clr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_q == LAST) |-> clr_i);
  assert_rise_after_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pwm_i);
  assert_fall_after_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !pwm_i);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(pwm_i));
  assert_one_set_per_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !set_seen_q);
  assert_pulse_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && clr_i));
endmodule

bind motor_pwm_gen pwm_gen_chk #(.PERIOD(PERIOD)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .pwm_i  (pwm_o),
  .set_i  (set_pulse_o),
  .clr_i  (clr_pulse_o)
);

// File: tb/motor_pwm_gen_bench.sv
module motor_pwm_gen_bench;
  localparam int SPEED_W = 8;
  localparam int STEP    = 2;
  localparam int P       = (1 << SPEED_W) * STEP;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [SPEED_W-1:0] speed_i = '0;
  logic               speed_upd_i = 1'b0;
  logic               pwm_o, set_pulse_o, clr_pulse_o;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  motor_pwm_gen #(.SPEED_W(SPEED_W), .STEP_CLKS(STEP)) u_motor_pwm_gen (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .speed_i     (speed_i),
    .speed_upd_i (speed_upd_i),
    .pwm_o       (pwm_o),
    .set_pulse_o (set_pulse_o),
    .clr_pulse_o (clr_pulse_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // window = the P clocks after a clear pulse, ending on the next clear pulse
  task automatic run_window(input int st_a, input int v_a, input int st_b, input int v_b,
                            output int high, output int nset, output int set_idx,
                            output int nclr, output int clr_idx);
    int guard = 0;
    high = 0; nset = 0; set_idx = -1; nclr = 0; clr_idx = -1;
    while (!clr_pulse_o && guard < P + 2) begin
      @(negedge clk);
      guard++;
    end
    chk("R1 sync", int'(clr_pulse_o), 1);
    if (st_a == 0) begin speed_i = SPEED_W'(v_a); speed_upd_i = 1'b1; end
    for (int i = 0; i < P; i++) begin
      @(negedge clk);
      speed_upd_i = 1'b0;
      if (pwm_o) high++;
      if (set_pulse_o) begin nset++; set_idx = i; end
      if (clr_pulse_o) begin nclr++; clr_idx = i; end
      if (st_a == i + 1) begin speed_i = SPEED_W'(v_a); speed_upd_i = 1'b1; end
      if (st_b == i + 1) begin speed_i = SPEED_W'(v_b); speed_upd_i = 1'b1; end
    end
  endtask

  task automatic expect_window(input string req, input int s, input int st_a, input int v_a,
                               input int st_b, input int v_b);
    int high, nset, set_idx, nclr, clr_idx;
    run_window(st_a, v_a, st_b, v_b, high, nset, set_idx, nclr, clr_idx);
    chk({req, " high clocks"}, high, s * STEP);
    chk("R1 clear count", nclr, 1);
    chk("R1 clear position", clr_idx, P - 1);
    if (s == 0) begin
      chk({req, " R5 no set pulse"}, nset, 0);
    end else begin
      chk({req, " R3 set count"}, nset, 1);
      chk({req, " R3 set position"}, set_idx, P - 1 - s * STEP);
    end
  endtask

  task automatic test_reset;
    int high = 0, clr_idx = -1, set_idx = -1;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 pwm in reset", int'(pwm_o), 0);
    chk("R4 set in reset", int'(set_pulse_o), 0);
    chk("R4 clr in reset", int'(clr_pulse_o), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < P; i++) begin
      if (i > 0) @(negedge clk);
      if (pwm_o) high++;
      if (set_pulse_o && set_idx < 0) set_idx = i;
      if (clr_pulse_o && clr_idx < 0) clr_idx = i;
    end
    chk("R4 first-period high clocks", high, (P / 2));
    chk("R4 first set position", set_idx, P - 1 - P / 2);
    chk("R1 first clear clock", clr_idx, P - 1);
  endtask

  task automatic test_mid_strobe;      // R7
    expect_window("R7 old value kept", 128, 5, 200, -1, 0);
    expect_window("R7 new value applied", 200, -1, 0, -1, 0);
  endtask

  task automatic test_zero;            // R5
    expect_window("R5 pre", 200, 7, 0, -1, 0);
    expect_window("R5 speed zero", 0, -1, 0, -1, 0);
  endtask

  task automatic test_full;            // R6
    expect_window("R6 pre", 0, 9, 255, -1, 0);
    expect_window("R6 full forward", 255, -1, 0, -1, 0);
  endtask

  task automatic test_small;           // R3
    expect_window("R3 pre", 255, 3, 1, -1, 0);
    expect_window("R3 speed one", 1, -1, 0, -1, 0);
  endtask

  task automatic test_boundary_strobe; // R8
    expect_window("R8 boundary strobe not yet", 1, 0, 60, -1, 0);
    expect_window("R8 applied one period later", 60, -1, 0, -1, 0);
  endtask

  task automatic test_double_strobe;   // R9
    expect_window("R9 pre", 60, 30, 30, 200, 90);
    expect_window("R9 last strobe wins", 90, -1, 0, -1, 0);
  endtask

  task automatic test_no_strobe;       // R10
    speed_i = 8'd7;
    expect_window("R10 unstrobed change", 90, -1, 0, -1, 0);
    speed_i = 8'd250;
    expect_window("R10 unstrobed change again", 90, -1, 0, -1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_mid_strobe();
    test_zero();
    test_full();
    test_small();
    test_boundary_strobe();
    test_double_strobe();
    test_no_strobe();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule